// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block tells a DDR SDRAM controller when a refresh is owed. An interval timer produces one refresh obligation per average refresh interval. The obligations are counted, so a busy controller may postpone refreshes and issue them later. The block raises an urgent flag once the number owed reaches a threshold. That threshold sits below the ceiling on postponed refreshes and below the hard limit on the time between two refreshes. The controller takes a refresh by pulsing a grant while the request is up. After each accepted refresh the block holds a busy window for the refresh cycle time. While that window is open, clock enable must stay high.

The block also sequences self-refresh. A one-cycle enter pulse puts it into self-refresh, which freezes the interval timer and forgives any refreshes still owed. A one-cycle exit pulse then starts the two recovery delays. Non-read commands are allowed once the shorter delay has run out, and reads once the longer one has. The controller uses two ready outputs to know when it may issue commands. Command encoding and bank precharge are left to the controller.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is held and just after it is released, `ref_req`, `ref_urgent` and `ref_busy` are low, and `cmd_ready` and `read_ready` are high.
- R2: Outside self-refresh, one refresh becomes owed every `INTERVAL` clock cycles. With no grants, `ref_req` first rises after exactly `INTERVAL` rising edges following reset release. Once that refresh is granted, the next one becomes owed `INTERVAL` edges after the first.
- R3: Owed refreshes accumulate. Each accepted grant retires exactly one, and `ref_req` stays available (outside busy windows) until none is owed. The count never goes above `MAX_DEBT`.
- R4: `ref_urgent` is high together with `ref_req` when at least `URGENT_AT` refreshes are owed. It is low when fewer are owed.
- R5: A grant accepted at a rising edge makes `ref_busy` high for the next `TRFC` cycles exactly. During that window `ref_req`, `cmd_ready` and `read_ready` are low, and `cke` must be high.
- R6: A grant sampled while `ref_req` is low has no effect. It does not open or extend a busy window, and it does not retire an owed refresh.
- R7: The number of cycles since the last accepted refresh (or since reset or self-refresh exit) never exceeds `MAX_GAP`. The urgent flag rises before that limit.
- R8: An accepted enter pulse puts the block in self-refresh on the next edge. There `ref_req`, `cmd_ready` and `read_ready` are low, the owed count is cleared and the interval timer holds its phase.
- R9: After an exit pulse sampled at edge X, `cmd_ready` is high from X+`XS_NONREAD` and `read_ready` is high from X+`XS_READ`. Both are low before those edges.
- R10: An enter pulse sampled while `ref_busy` is high is ignored. An exit pulse sampled outside self-refresh is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Controller issues a refresh this cycle |
| cke | input | 1 | Clock enable level driven to the memory |
| sr_enter | input | 1 | Request to enter self-refresh (one-cycle pulse) |
| sr_exit | input | 1 | Request to leave self-refresh (one-cycle pulse) |
| ref_req | output | 1 | At least one refresh owed and block free to take it |
| ref_urgent | output | 1 | Request is pressing: owed count at or above threshold |
| ref_busy | output | 1 | Refresh cycle time still running |
| cmd_ready | output | 1 | Non-read commands allowed |
| read_ready | output | 1 | Read commands allowed |

## Verification
The hardest state to reach is self-refresh entered with refreshes already owed and the interval timer part-way through its count. Both the clearing of the debt and the freezing of the timer are visible only through the timing of the first request after exit. The stimulus lets two refreshes fall due and enters self-refresh at a known timer phase. It then leaves self-refresh and checks that the request rises exactly at the remainder of the interval and that a single grant clears it. The exit-delay boundaries and the busy-window edges are each sampled one cycle before and at the edge where they change.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    typedef enum logic [1:0] {
        SR_RUN  = 2'd0,
        SR_SELF = 2'd1,
        SR_EXIT = 2'd2
    } sr_mode_e;

endpackage

// File: rtl/refsch_interval.sv
module refsch_interval #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } ivl_st_t;

    ivl_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (!freeze) begin
            if (s_q.cnt == TW'(INTERVAL - 1)) begin
                tick      = 1'b1;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt   = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/refsch_debt.sv
module refsch_debt #(
    parameter int MAX_DEBT  = 8,
    parameter int URGENT_AT = 7,
    parameter int MAX_GAP   = 14060
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    input  logic clear,
    output logic pending,
    output logic urgent
);
    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam int GW = $clog2(MAX_GAP + 2);

    typedef struct packed {
        logic [DW-1:0] debt;
        logic [GW-1:0] gap;
    } debt_st_t;

    debt_st_t s_d, s_q;
    logic     retire;

    always_comb begin
        s_d    = s_q;
        retire = take && (s_q.debt != '0);
        if (clear) begin
            s_d.debt = '0;
            s_d.gap  = '0;
        end else begin
            if (tick && !retire) begin
                if (s_q.debt != DW'(MAX_DEBT)) s_d.debt = s_q.debt + 1'b1;
            end else if (!tick && retire) begin
                s_d.debt = s_q.debt - 1'b1;
            end
            if (retire)                          s_d.gap = '0;
            else if (s_q.gap != GW'(MAX_GAP + 1)) s_d.gap = s_q.gap + 1'b1;
        end
    end

    assign pending = (s_q.debt != '0);
    assign urgent  = (s_q.debt >= DW'(URGENT_AT));

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: a new obligation must never arrive with the ceiling already reached
    assert_debt_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !retire && !clear) |-> (s_q.debt < DW'(MAX_DEBT)))
        else $error("owed refresh count would pass its ceiling");

    // R7: time since the last accepted refresh stays within the hard limit
    assert_gap_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.gap <= GW'(MAX_GAP))
        else $error("refresh gap limit exceeded");

endmodule

// File: rtl/refsch_selfref.sv
module refsch_selfref
    import refsch_pkg::*;
#(
    parameter int XS_NONREAD = 15,
    parameter int XS_READ    = 200
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enter_ok,
    input  logic     exit_req,
    output sr_mode_e mode,
    output logic     nonread_ok,
    output logic     read_ok
);
    localparam int XW = $clog2(XS_READ + 1);

    typedef struct packed {
        sr_mode_e      mode;
        logic [XW-1:0] xcnt;
    } sr_st_t;

    sr_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.mode)
            SR_RUN: begin
                if (enter_ok) s_d.mode = SR_SELF;
            end
            SR_SELF: begin
                if (exit_req) begin
                    s_d.mode = SR_EXIT;
                    s_d.xcnt = '0;
                end
            end
            SR_EXIT: begin
                if (s_q.xcnt >= XW'(XS_READ)) begin
                    s_d.mode = SR_RUN;
                    s_d.xcnt = '0;
                end else begin
                    s_d.xcnt = s_q.xcnt + 1'b1;
                end
            end
            default: s_d.mode = SR_RUN;
        endcase
    end

    assign mode       = s_q.mode;
    assign nonread_ok = (s_q.mode == SR_RUN) ||
                        ((s_q.mode == SR_EXIT) && (s_q.xcnt >= XW'(XS_NONREAD)));
    assign read_ok    = (s_q.mode == SR_RUN) ||
                        ((s_q.mode == SR_EXIT) && (s_q.xcnt >= XW'(XS_READ)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode <= SR_RUN;
            s_q.xcnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R9: reads never open before other commands do
    assert_read_after_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        read_ok |-> nonread_ok)
        else $error("read allowed before non-read commands");

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import refsch_pkg::*;
#(
    parameter int INTERVAL   = 1560,
    parameter int MAX_DEBT   = 8,
    parameter int URGENT_AT  = 7,
    parameter int MAX_GAP    = 14060,
    parameter int TRFC       = 15,
    parameter int XS_NONREAD = 15,
    parameter int XS_READ    = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic cke,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic ref_req,
    output logic ref_urgent,
    output logic ref_busy,
    output logic cmd_ready,
    output logic read_ready
);
    localparam int BW = $clog2(TRFC + 1);

    typedef struct packed {
        logic [BW-1:0] bcnt;
    } busy_st_t;

    busy_st_t s_d, s_q;
    sr_mode_e mode;
    logic     tick, pending, urgent, nonread_ok, read_ok;
    logic     take, enter_ok, in_self;

    assign in_self  = (mode == SR_SELF);
    assign ref_busy = (s_q.bcnt != '0);
    assign ref_req  = pending && !ref_busy && (mode == SR_RUN);
    assign take     = ref_gnt && ref_req;
    assign enter_ok = sr_enter && !ref_busy;

    refsch_interval #(.INTERVAL(INTERVAL)) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (in_self),
        .tick   (tick)
    );

    refsch_debt #(
        .MAX_DEBT  (MAX_DEBT),
        .URGENT_AT (URGENT_AT),
        .MAX_GAP   (MAX_GAP)
    ) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .take    (take),
        .clear   (in_self),
        .pending (pending),
        .urgent  (urgent)
    );

    refsch_selfref #(
        .XS_NONREAD (XS_NONREAD),
        .XS_READ    (XS_READ)
    ) u_selfref (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_ok   (enter_ok),
        .exit_req   (sr_exit),
        .mode       (mode),
        .nonread_ok (nonread_ok),
        .read_ok    (read_ok)
    );

    always_comb begin
        s_d = s_q;
        if (take)               s_d.bcnt = BW'(TRFC);
        else if (s_q.bcnt != '0) s_d.bcnt = s_q.bcnt - 1'b1;
    end

    assign ref_urgent = ref_req && urgent;
    assign cmd_ready  = nonread_ok && !ref_busy;
    assign read_ready = read_ok && !ref_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: clock enable stays high for the whole refresh cycle
    assert_cke_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_busy |-> cke)
        else $error("clock enable dropped during refresh cycle");

    // R5: an accepted grant opens the busy window and closes command issue
    assert_busy_follows_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_gnt && ref_req) |=> (ref_busy && !cmd_ready && !read_ready))
        else $error("grant not followed by busy window");

    // R8: nothing is offered to the controller while in self-refresh
    assert_sr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SR_SELF) |-> (!ref_req && !cmd_ready && !read_ready))
        else $error("activity offered during self-refresh");

endmodule

// File: tb/tb_refresh_scheduler.sv
`timescale 1ns/1ps
module tb_refresh_scheduler;
    localparam int P_INTERVAL = 20;
    localparam int P_MAXDEBT  = 8;
    localparam int P_URGENT   = 6;
    localparam int P_MAXGAP   = 190;
    localparam int P_TRFC     = 5;
    localparam int P_XSN      = 4;
    localparam int P_XSR      = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0, cke = 1'b1, sr_enter = 1'b0, sr_exit = 1'b0;
    logic ref_req, ref_urgent, ref_busy, cmd_ready, read_ready;

    int n_checks = 0;
    int n_fails  = 0;
    int edges    = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    refresh_scheduler #(
        .INTERVAL(P_INTERVAL), .MAX_DEBT(P_MAXDEBT), .URGENT_AT(P_URGENT),
        .MAX_GAP(P_MAXGAP), .TRFC(P_TRFC), .XS_NONREAD(P_XSN), .XS_READ(P_XSR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .cke(cke),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .ref_busy(ref_busy),
        .cmd_ready(cmd_ready), .read_ready(read_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, edges, act, exp);
        end
    endtask

    task automatic go(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic go_to(input int k);
        while (edges < k) go(1);
    endtask

    task automatic do_reset();
        ref_gnt = 0; sr_enter = 0; sr_exit = 0;
        @(negedge clk);
        rst_n = 0;
        go(3);
        rst_n = 1;
        edges = 0;
    endtask

    task automatic grant();
        ref_gnt = 1;
        go(1);
        ref_gnt = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 40; i++) begin
            while (ref_busy) go(1);
            if (!ref_req) break;
            grant();
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 req", ref_req, 0);
        chk("R1 urgent", ref_urgent, 0);
        chk("R1 busy", ref_busy, 0);
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 read_ready", read_ready, 1);
    endtask

    task automatic t_interval();
        do_reset();
        go_to(P_INTERVAL - 1);
        chk("R2 req before first interval", ref_req, 0);
        go(1);
        chk("R2 req at first interval", ref_req, 1);
        grant();
        go_to(2 * P_INTERVAL - 1);
        chk("R2 req before second interval", ref_req, 0);
        go(1);
        chk("R2 req at second interval", ref_req, 1);
    endtask

    task automatic t_debt();
        int taken;
        do_reset();
        go_to(3 * P_INTERVAL);
        chk("R3 req with three owed", ref_req, 1);
        taken = 0;
        for (int i = 0; i < 10; i++) begin
            while (ref_busy) go(1);
            if (!ref_req) break;
            grant();
            taken++;
        end
        chk("R3 grants to clear three owed", taken, 3);
    endtask

    task automatic t_urgent();
        do_reset();
        go_to(P_URGENT * P_INTERVAL - 1);
        chk("R4 urgent below threshold", ref_urgent, 0);
        go(1);
        chk("R4 urgent at threshold", ref_urgent, 1);
        chk("R7 urgent before gap limit", (edges < P_MAXGAP) ? 1 : 0, 1);
        grant();
        while (ref_busy) go(1);
        chk("R4 req after one retired", ref_req, 1);
        chk("R4 urgent after one retired", ref_urgent, 0);
        drain();
    endtask

    task automatic t_busy();
        do_reset();
        go_to(P_INTERVAL);
        grant();
        chk("R5 busy first cycle", ref_busy, 1);
        chk("R5 cmd_ready in busy", cmd_ready, 0);
        chk("R5 read_ready in busy", read_ready, 0);
        go(P_TRFC - 1);
        chk("R5 busy last cycle", ref_busy, 1);
        chk("R5 req in busy", ref_req, 0);
        go(1);
        chk("R5 busy ended", ref_busy, 0);
        chk("R5 cmd_ready after busy", cmd_ready, 1);
    endtask

    task automatic t_ignore_gnt();
        do_reset();
        grant();
        chk("R6 no busy from unrequested grant", ref_busy, 0);
        go_to(P_INTERVAL);
        chk("R6 request still owed", ref_req, 1);
        grant();
        go(1);
        grant();
        go_to(P_INTERVAL + P_TRFC);
        chk("R6 busy not extended (last)", ref_busy, 1);
        go(1);
        chk("R6 busy not extended (end)", ref_busy, 0);
        chk("R6 req after window", ref_req, 0);
        go_to(2 * P_INTERVAL);
        chk("R6 next obligation on time", ref_req, 1);
        drain();
    endtask

    task automatic t_selfref();
        int x;
        do_reset();
        go_to(2 * P_INTERVAL + 3);
        chk("R8 req before entry", ref_req, 1);
        sr_enter = 1;
        go(1);
        sr_enter = 0;
        chk("R8 req in self-refresh", ref_req, 0);
        chk("R8 cmd_ready in self-refresh", cmd_ready, 0);
        chk("R8 read_ready in self-refresh", read_ready, 0);
        go(30);
        chk("R8 still quiet", cmd_ready + read_ready + ref_req, 0);
        sr_exit = 1;
        go(1);
        sr_exit = 0;
        x = edges;
        go_to(x + P_XSN - 1);
        chk("R9 cmd_ready before delay", cmd_ready, 0);
        go(1);
        chk("R9 cmd_ready at delay", cmd_ready, 1);
        go_to(x + P_XSR - 1);
        chk("R9 read_ready before delay", read_ready, 0);
        go(1);
        chk("R9 read_ready at delay", read_ready, 1);
        // timer held phase 4 through self-refresh; owed count was cleared
        go_to(x + P_INTERVAL - 5);
        chk("R8 no req before resumed tick", ref_req, 0);
        go(1);
        chk("R8 req at resumed tick", ref_req, 1);
        grant();
        while (ref_busy) go(1);
        chk("R8 debt was cleared", ref_req, 0);
    endtask

    task automatic t_sr_ignored();
        do_reset();
        go_to(P_INTERVAL);
        grant();
        go(1);
        sr_enter = 1;
        go(1);
        sr_enter = 0;
        while (ref_busy) go(1);
        chk("R10 enter during busy ignored (cmd)", cmd_ready, 1);
        chk("R10 enter during busy ignored (read)", read_ready, 1);
        sr_exit = 1;
        go(1);
        sr_exit = 0;
        chk("R10 exit while running ignored (cmd)", cmd_ready, 1);
        go(1);
        chk("R10 exit while running ignored (read)", read_ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_interval();
        t_debt();
        t_urgent();
        t_busy();
        t_ignore_gnt();
        t_selfref();
        t_sr_ignored();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule